// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts a 64-bit virtual address into one of three outcomes. The address is either handed on for translation through the TLB, turned straight into a physical address, or refused with an address error. Two inputs select how the address is read. One chooses kernel or user privilege. The other chooses 32-bit or 64-bit addressing. In 32-bit addressing only the low word counts, and the block sign-extends it from bit 31 before it classifies it.

The memory-access path of a processor core uses the block ahead of the TLB lookup. The core presents an address with `in_valid`, and the result appears one clock later on registered outputs. When the result is a TLB lookup, the block also gives the address the TLB must search: the sign-extended form in 32-bit addressing, and the raw address in 64-bit addressing. Supervisor segments and cache attributes are not decoded. Any region that is not a hole and not an unmapped window goes to the TLB.

Top module: `vaddr_seg_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid`, `to_tlb`, `direct`, `addr_error`, `paddr` and `tlb_vaddr` are all zero.
- R2: An address taken with `in_valid` at a rising edge produces its result on the outputs just after that edge. `out_valid` is high exactly in the cycles that follow a taken address.
- R3: While `out_valid` is high, exactly one of `to_tlb`, `direct` and `addr_error` is high. While it is low, all three are low.
- R4: In 32-bit kernel mode (`is_kernel`=1, `wide`=0), segment `vaddr[31:29]` decides the result. Segments 4 and 5 are direct, with `paddr` = `vaddr[28:0]` zero-extended. Segments 0, 1, 2, 3, 6 and 7 go to the TLB. `vaddr[63:32]` has no effect.
- R5: In 32-bit user mode (`is_kernel`=0, `wide`=0), an address with `vaddr[31]`=0 goes to the TLB. Any address with `vaddr[31]`=1 is an address error.
- R6: When `to_tlb` is high, `tlb_vaddr` is the sign extension of `vaddr[31:0]` in 32-bit mode and the unchanged `vaddr` in 64-bit mode. Otherwise `tlb_vaddr` is zero.
- R7: In 64-bit user mode (`is_kernel`=0, `wide`=1), addresses up to 0x000000FFFFFFFFFF go to the TLB. Every other address is an address error.
- R8: In 64-bit kernel mode these ranges go to the TLB: 0 to 0x000000FFFFFFFFFF, 0x4000000000000000 to 0x400000FFFFFFFFFF, 0xC000000000000000 to 0xC00000FF7FFFFFFF, and 0xFFFFFFFFC0000000 upward.
- R9: In 64-bit kernel mode, an address with `vaddr[63:62]`=2'b10 lies in the direct-physical window. It is direct with `paddr` = `vaddr[31:0]` when `vaddr[58:32]` is all zero. Otherwise it is an address error.
- R10: In 64-bit kernel mode, addresses from 0xFFFFFFFF80000000 to 0xFFFFFFFFBFFFFFFF are direct, with `paddr` = `vaddr[31:0]` minus (`vaddr[31:28]` shifted left by 28).
- R11: In 64-bit kernel mode, these ranges are address errors: 0x0000010000000000 to 0x3FFFFFFFFFFFFFFF, 0x4000010000000000 to 0x7FFFFFFFFFFFFFFF, and 0xC00000FF80000000 to 0xFFFFFFFF7FFFFFFF.
- R12: `paddr` is zero whenever `direct` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An address is presented this cycle |
| vaddr | input | 64 | Virtual address |
| is_kernel | input | 1 | 1 = kernel privilege, 0 = user |
| wide | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| out_valid | output | 1 | A result is on the outputs |
| to_tlb | output | 1 | Address must be translated by the TLB |
| direct | output | 1 | Address maps straight to `paddr` |
| addr_error | output | 1 | Address is illegal in this mode |
| paddr | output | 32 | Physical address for a direct result |
| tlb_vaddr | output | 64 | Address to look up in the TLB |

## Verification
The sign extension of 32-bit mode and the region map of 64-bit mode can both act on one raw address, and then only the `wide` input decides between them. The bench provokes this by sending the same address in consecutive cycles with `wide` toggled. For example, 0x0000000080000010 is direct in 32-bit kernel mode but goes to the TLB in 64-bit kernel mode. 0xFFFFFFFF90000000 is direct in both modes but gives a different `paddr` in each. A scoreboard queue judges every result against a reference model written from the requirements, so a mode-mixing error shows as a wrong outcome or a wrong address on that exact cycle.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int VA_W = 64;
  localparam int PA_W = 32;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_TLB    = 2'd1,
    CLS_DIRECT = 2'd2,
    CLS_ERR    = 2'd3
  } vseg_cls_e;

  typedef struct packed {
    vseg_cls_e         cls;
    logic [PA_W-1:0]   pa;
    logic [VA_W-1:0]   tva;
  } vseg_res_t;
endpackage

// File: rtl/vseg_dec32.sv
module vseg_dec32
  import vseg_pkg::*;
#(
  parameter int LO_W  = 32,
  parameter int SEG_W = 3
) (
  input  logic [LO_W-1:0] addr_lo,
  input  logic            is_kernel,
  output vseg_res_t       res
);
  localparam int SEG_LSB = LO_W - SEG_W;

  logic [SEG_W-1:0] seg;
  logic [VA_W-1:0]  sext;
  logic             seg_unmapped;

  assign seg  = addr_lo[LO_W-1:SEG_LSB];
  assign sext = {{(VA_W-LO_W){addr_lo[LO_W-1]}}, addr_lo};
  // segments 4 and 5 are the unmapped kernel windows
  assign seg_unmapped = (seg == SEG_W'(4)) || (seg == SEG_W'(5));

  always_comb begin
    res = '0;
    if (is_kernel) begin
      if (seg_unmapped) begin
        res.cls = CLS_DIRECT;
        res.pa  = PA_W'(addr_lo[SEG_LSB-1:0]);
      end else begin
        res.cls = CLS_TLB;
        res.tva = sext;
      end
    end else if (!addr_lo[LO_W-1]) begin
      res.cls = CLS_TLB;
      res.tva = sext;
    end else begin
      res.cls = CLS_ERR;
    end
  end
endmodule

// File: rtl/vseg_dec64.sv
module vseg_dec64
  import vseg_pkg::*;
#(
  parameter int REGION_LSB = 40
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            is_kernel,
  output vseg_res_t       res
);
  localparam int HI_W = VA_W - REGION_LSB;

  logic [HI_W-1:0] hi;
  logic in_user, in_super, in_kseg, in_ckhigh, in_cklow, in_phys, phys_ok;
  logic [PA_W-1:0] ck_pa;

  assign hi        = vaddr[VA_W-1:REGION_LSB];
  assign in_user   = (hi == '0);
  assign in_super  = (hi == {2'b01, {(HI_W-2){1'b0}}});
  assign in_kseg   = (hi == {2'b11, {(HI_W-2){1'b0}}}) && !(&vaddr[REGION_LSB-1:31]);
  assign in_ckhigh = &vaddr[VA_W-1:30];
  assign in_cklow  = (&vaddr[VA_W-1:31]) && !vaddr[30];
  assign in_phys   = (vaddr[VA_W-1:VA_W-2] == 2'b10);
  assign phys_ok   = (vaddr[58:32] == '0);
  assign ck_pa     = vaddr[PA_W-1:0] - {vaddr[31:28], 28'h0};

  always_comb begin
    res = '0;
    if (!is_kernel) begin
      if (in_user) begin
        res.cls = CLS_TLB;
        res.tva = vaddr;
      end else begin
        res.cls = CLS_ERR;
      end
    end else if (in_user || in_super || in_kseg || in_ckhigh) begin
      res.cls = CLS_TLB;
      res.tva = vaddr;
    end else if (in_phys) begin
      if (phys_ok) begin
        res.cls = CLS_DIRECT;
        res.pa  = vaddr[PA_W-1:0];
      end else begin
        res.cls = CLS_ERR;
      end
    end else if (in_cklow) begin
      res.cls = CLS_DIRECT;
      res.pa  = ck_pa;
    end else begin
      res.cls = CLS_ERR;
    end
  end
endmodule

// File: rtl/vaddr_seg_decoder.sv
module vaddr_seg_decoder
  import vseg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [VA_W-1:0] vaddr,
  input  logic            is_kernel,
  input  logic            wide,
  output logic            out_valid,
  output logic            to_tlb,
  output logic            direct,
  output logic            addr_error,
  output logic [PA_W-1:0] paddr,
  output logic [VA_W-1:0] tlb_vaddr
);
  vseg_res_t r32, r64, r_sel, r_q;
  logic      v_q;

  vseg_dec32 u_dec32 (
    .addr_lo   (vaddr[31:0]),
    .is_kernel (is_kernel),
    .res       (r32)
  );

  vseg_dec64 u_dec64 (
    .vaddr     (vaddr),
    .is_kernel (is_kernel),
    .res       (r64)
  );

  always_comb begin
    r_sel = '0;
    if (in_valid) r_sel = wide ? r64 : r32;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          r_q <= '0;
        end else begin
          v_q <= in_valid;
          r_q <= r_sel;
        end
      end

      // R3: exactly one outcome per valid result, none otherwise
      a_r3_one_outcome: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones({to_tlb, direct, addr_error}) == 1);
      a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(to_tlb || direct || addr_error));
      // R2: one cycle from input to result
      a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      // R5: user mode never yields a direct mapping (R7 likewise)
      a_r5_user_no_direct: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_kernel) |=> !direct);
      // R9: nonzero middle bits in the physical window are illegal
      a_r9_phys_bad: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_kernel && wide && vaddr[63:62] == 2'b10 && |vaddr[58:32])
        |=> addr_error);
      // R12: physical address only carried by direct results
      a_r12_paddr_zero: assert property (@(posedge clk) disable iff (rst)
        !direct |-> paddr == '0);
      // R6: 32-bit lookups are sign-extended
      a_r6_sext: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide) |=> (!to_tlb || tlb_vaddr[63:32] == {32{tlb_vaddr[31]}}));
    end else begin : g_comb
      assign v_q = in_valid;
      assign r_q = r_sel;
    end
  endgenerate

  assign out_valid  = v_q;
  assign to_tlb     = (r_q.cls == CLS_TLB);
  assign direct     = (r_q.cls == CLS_DIRECT);
  assign addr_error = (r_q.cls == CLS_ERR);
  assign paddr      = r_q.pa;
  assign tlb_vaddr  = r_q.tva;
endmodule

// File: tb/test_vaddr_seg_decoder.sv
module test_vaddr_seg_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] vaddr = '0;
  logic        is_kernel = 1'b0;
  logic        wide = 1'b0;
  logic        out_valid, to_tlb, direct, addr_error;
  logic [31:0] paddr;
  logic [63:0] tlb_vaddr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [2:0]  flags;   // {to_tlb, direct, addr_error}
    logic [31:0] pa;
    logic [63:0] tva;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vaddr_seg_decoder i_vaddr_seg_decoder (
    .clk, .rst, .in_valid, .vaddr, .is_kernel, .wide,
    .out_valid, .to_tlb, .direct, .addr_error, .paddr, .tlb_vaddr
  );

  function automatic exp_t model(logic [63:0] v, logic k, logic w, string tag);
    exp_t e;
    logic [63:0] s;
    e.flags = 3'b000; e.pa = '0; e.tva = '0; e.tag = tag;
    if (!w) begin
      s = {{32{v[31]}}, v[31:0]};
      if (k && (v[31:29] == 3'd4 || v[31:29] == 3'd5)) begin
        e.flags = 3'b010; e.pa = {3'b000, v[28:0]};
      end else if (k || !v[31]) begin
        e.flags = 3'b100; e.tva = s;
      end else e.flags = 3'b001;
    end else if (!k) begin
      if (v <= 64'h0000_00FF_FFFF_FFFF) begin e.flags = 3'b100; e.tva = v; end
      else e.flags = 3'b001;
    end else begin
      if (v <= 64'h0000_00FF_FFFF_FFFF ||
          (v >= 64'h4000_0000_0000_0000 && v <= 64'h4000_00FF_FFFF_FFFF) ||
          (v >= 64'hC000_0000_0000_0000 && v <= 64'hC000_00FF_7FFF_FFFF) ||
          v >= 64'hFFFF_FFFF_C000_0000) begin
        e.flags = 3'b100; e.tva = v;
      end else if (v >= 64'h8000_0000_0000_0000 && v <= 64'hBFFF_FFFF_FFFF_FFFF) begin
        if ((v & 64'h07FF_FFFF_0000_0000) == 0) begin e.flags = 3'b010; e.pa = v[31:0]; end
        else e.flags = 3'b001;
      end else if (v >= 64'hFFFF_FFFF_8000_0000 && v <= 64'hFFFF_FFFF_BFFF_FFFF) begin
        e.flags = 3'b010; e.pa = v[31:0] - {v[31:28], 28'h0};
      end else e.flags = 3'b001;
    end
    return e;
  endfunction

  task automatic drive(logic [63:0] v, logic k, logic w, string tag);
    @(negedge clk);
    vaddr = v; is_kernel = k; wide = w; in_valid = 1'b1;
    q.push_back(model(v, k, w, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      vaddr = 64'hDEAD_BEEF_0BAD_F00D;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst) continue;
      if (out_valid) begin
        exp_t e;
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R2: actual=unexpected result expected=no result");
        end else begin
          e = q.pop_front();
          if ({to_tlb, direct, addr_error} !== e.flags || paddr !== e.pa ||
              tlb_vaddr !== e.tva) begin
            bad++;
            $display("FAIL %s: actual flags=%b pa=%h tva=%h expected flags=%b pa=%h tva=%h",
                     e.tag, {to_tlb, direct, addr_error}, paddr, tlb_vaddr,
                     e.flags, e.pa, e.tva);
          end
        end
      end else begin
        total++;
        if ({to_tlb, direct, addr_error} !== 3'b000 || q.size() != 0) begin
          bad++;
          $display("FAIL R3: actual flags=%b pending=%0d expected flags=000 pending=0",
                   {to_tlb, direct, addr_error}, q.size());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R2: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs even with an address presented
    in_valid = 1'b1; vaddr = 64'hFFFF_FFFF_8000_0010; is_kernel = 1'b1; wide = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (out_valid || to_tlb || direct || addr_error || paddr != 0 || tlb_vaddr != 0) begin
      bad++;
      $display("FAIL R1: actual v=%b f=%b pa=%h expected all zero",
               out_valid, {to_tlb, direct, addr_error}, paddr);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b0;
    @(posedge clk); #1;
    total++;
    if (out_valid || to_tlb || direct || addr_error || paddr != 0 || tlb_vaddr != 0) begin
      bad++;
      $display("FAIL R1: actual v=%b after reset expected 0", out_valid);
    end

    // R4: 32-bit kernel segments
    drive(64'h0000_0000_8000_1234, 1, 0, "R4 seg4");
    drive(64'h0000_0000_BFC0_0000, 1, 0, "R4 seg5");
    drive(64'h0000_0000_0040_0000, 1, 0, "R4 seg0");
    drive(64'h0000_0000_C000_0000, 1, 0, "R4 seg6");
    drive(64'h0000_0000_E000_0010, 1, 0, "R4 seg7");
    drive(64'h1234_5678_A000_0004, 1, 0, "R4 upper ignored");
    // R5: 32-bit user
    drive(64'h0000_0000_7FFF_FFFF, 0, 0, "R5 top of user");
    drive(64'h0000_0000_8000_0000, 0, 0, "R5 kernel addr");
    drive(64'hFFFF_FFFF_FFFF_FFF0, 0, 0, "R5 high");
    idle(2);
    // R6 / R7: 64-bit user
    drive(64'h0000_00FF_FFFF_FFFF, 0, 1, "R7 top");
    drive(64'h0000_0100_0000_0000, 0, 1, "R7 above");
    drive(64'hFFFF_FFFF_8000_0000, 0, 1, "R7 kernel");
    drive(64'hFFFF_FFFF_8000_0000, 0, 0, "R6 sext user err");
    // R8: 64-bit kernel TLB ranges
    drive(64'h0, 1, 1, "R8 zero");
    drive(64'h4000_00FF_FFFF_FFFF, 1, 1, "R8 super top");
    drive(64'hC000_00FF_7FFF_FFFF, 1, 1, "R8 kseg top");
    drive(64'hFFFF_FFFF_E000_0000, 1, 1, "R8 ck3");
    drive(64'hFFFF_FFFF_C000_1000, 1, 1, "R8 ck2");
    // R9: physical window
    drive(64'h9000_0000_1234_5678, 1, 1, "R9 valid");
    drive(64'h8800_0001_0000_0000, 1, 1, "R9 bit32");
    drive(64'hB800_0000_FFFF_FFFF, 1, 1, "R9 bit59");
    drive(64'h8400_0000_0000_0000, 1, 1, "R9 bit58");
    // R10: unmapped compatibility windows
    drive(64'hFFFF_FFFF_9ABC_DEF0, 1, 1, "R10 low");
    drive(64'hFFFF_FFFF_A000_0010, 1, 1, "R10 high");
    drive(64'hFFFF_FFFF_BFFF_FFFF, 1, 1, "R10 end");
    // R11: holes
    drive(64'h0000_0100_0000_0000, 1, 1, "R11 hole1 lo");
    drive(64'h3FFF_FFFF_FFFF_FFFF, 1, 1, "R11 hole1 hi");
    drive(64'h4000_0100_0000_0000, 1, 1, "R11 hole2 lo");
    drive(64'h7FFF_FFFF_FFFF_FFFF, 1, 1, "R11 hole2 hi");
    drive(64'hC000_00FF_8000_0000, 1, 1, "R11 hole3 lo");
    drive(64'hFFFF_FFFF_7FFF_FFFF, 1, 1, "R11 hole3 hi");
    idle(1);
    // same address, mode flipped cycle to cycle (R6, R12)
    drive(64'h0000_0000_8000_0010, 1, 0, "R12 32k direct");
    drive(64'h0000_0000_8000_0010, 1, 1, "R6 64k tlb");
    drive(64'hFFFF_FFFF_9000_0000, 1, 0, "R4 32k direct");
    drive(64'hFFFF_FFFF_9000_0000, 1, 1, "R10 64k direct");
    // random mix covering every mode (R3)
    for (int i = 0; i < 300; i++) begin
      logic [63:0] rv;
      rv = {$urandom, $urandom};
      case (i % 4)
        0: rv[63:40] = 24'h0;
        1: rv[63:32] = 32'hFFFF_FFFF;
        2: rv[63:59] = 5'b10000;
        default: ;
      endcase
      drive(rv, 1'($urandom), 1'($urandom), "R3 random");
      if (i % 37 == 0) idle(1);
    end
    idle(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule